// File: doc/BRIEF.md
# Smart Card Character Wait Monitor

This block supervises the spacing of characters on a half-duplex smart card link. It counts elementary time unit (etu) ticks from a reference character start. When the count passes a programmed limit, it raises a sticky wait-error flag. Software programs a 16-bit limit through a simple write/readback port, selects the link protocol (T=0 or T=1), and clears the flag by writing a one to a clear strobe.

The protocol setting controls two things: how the limit is scaled, and which character starts count. In T=0 the limit is sixty times the programmed value. The interval opens at each received character start. It closes at the next character start in either direction. In T=1 the limit equals the programmed value. Only received character starts take part in the timing. In both modes a programmed zero does not disable the check. Zero selects the smallest useful limit instead.

Top module: `sc_wait_mon`

## Requirements
- R1: The limit register is 16 bits wide and resets to 0. A cycle with `lim_we_i`=1 loads `lim_wdata_i`, and the stored value appears on `lim_rdata_o` from the next cycle.
- R2: With `proto_t1_i`=1 and a programmed value V>0, the flag stays 0 through V etu ticks after a received start. The flag sets on the edge of the tick that follows them (tick V+1).
- R3: With `proto_t1_i`=0 and V>0, the limit is 60*V etu. The flag stays 0 through 60*V ticks and sets on tick 60*V+1.
- R4: A programmed value of 0 acts as a limit of 60 etu in T=0 and 1 etu in T=1.
- R5: In T=1 a received start restarts the count from zero. A transmitted start has no effect on the timing.
- R6: In T=0 a received start restarts the count. A transmitted start ends the interval, and no error can occur until the next received start.
- R7: The flag is sticky. It stays 1 until a cycle with `err_clr_i`=1, after which it reads 0.
- R8: A violation in the same cycle as a clear leaves the flag at 1.
- R9: No timing runs while `en_i`=0, or after enable until the first received start. Dropping `en_i` stops timing but does not change the flag.
- R10: Each interval raises at most one error event. After a clear, further ticks without a new received start do not set the flag again. The internal count saturates and never wraps.
- R11: A start strobe in the same cycle as a tick wins. The count restarts from zero, and that tick neither counts nor triggers an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitor enable |
| proto_t1_i | input | 1 | 1 selects T=1 timing, 0 selects T=0 |
| lim_we_i | input | 1 | Limit register write strobe |
| lim_wdata_i | input | 16 | Limit write data |
| lim_rdata_o | output | 16 | Limit register readback |
| etu_tick_i | input | 1 | One-cycle pulse per elementary time unit |
| rx_start_i | input | 1 | Start of a received character |
| tx_start_i | input | 1 | Start of a transmitted character |
| err_clr_i | input | 1 | Write-one clear of the wait-error flag |
| wait_err_o | output | 1 | Sticky wait-error flag |

## Verification
Each internal state error shows up as a shift in the tick on which the flag rises. A bad scale or zero fallback moves the rise away from tick V+1, 61 or 2. A lost restart or a wrong direction rule makes the flag rise too early, or not at all, in the interval after a strobe. A stuck armed or tripped bit shows as a flag that rises before any traffic, or rises again after a clear with no new start. Every one of these appears on `wait_err_o` within one tick of the expected boundary. This lets the directed scenarios sample exactly at the limit tick and the tick after it.

// File: rtl/sc_wait_pkg.sv
package sc_wait_pkg;
  parameter int unsigned LIM_W   = 16;
  parameter int unsigned CNT_W   = 22;  // holds 60 * (2^16-1)
  parameter int unsigned T0_MULT = 60;
endpackage

// File: rtl/sc_wait_limit_reg.sv
module sc_wait_limit_reg #(
  parameter int unsigned W = sc_wait_pkg::LIM_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/sc_wait_scale.sv
module sc_wait_scale #(
  parameter int unsigned LIM_W = sc_wait_pkg::LIM_W,
  parameter int unsigned CNT_W = sc_wait_pkg::CNT_W,
  parameter int unsigned MULT  = sc_wait_pkg::T0_MULT
) (
  input  logic [LIM_W-1:0] raw_i,
  input  logic             t1_i,
  output logic [CNT_W-1:0] lim_o
);
  logic [CNT_W-1:0] base;
  // zero never disables: treat as one unit
  always_comb begin
    base = (raw_i == '0) ? CNT_W'(1) : CNT_W'(raw_i);
    lim_o = t1_i ? base : CNT_W'(base * CNT_W'(MULT));
  end
endmodule

// File: rtl/sc_wait_timer.sv
module sc_wait_timer #(
  parameter int unsigned CNT_W = sc_wait_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             viol_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  logic tripped_q;

  assign viol_o = en_i && armed_o && tick_i && !restart_i && !stop_i &&
                  !tripped_q && (cnt_o >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o   <= 1'b0;
      cnt_o     <= '0;
      tripped_q <= 1'b0;
    end else if (!en_i) begin
      armed_o   <= 1'b0;
      cnt_o     <= '0;
      tripped_q <= 1'b0;
    end else if (restart_i || stop_i) begin
      armed_o   <= restart_i;
      cnt_o     <= '0;
      tripped_q <= 1'b0;
    end else begin
      if (armed_o && tick_i && cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
      if (viol_o) tripped_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sc_wait_flag.sv
module sc_wait_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);  // set wins
  end
endmodule

// File: rtl/sc_wait_mon.sv
module sc_wait_mon
  import sc_wait_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             proto_t1_i,
  input  logic             lim_we_i,
  input  logic [LIM_W-1:0] lim_wdata_i,
  output logic [LIM_W-1:0] lim_rdata_o,
  input  logic             etu_tick_i,
  input  logic             rx_start_i,
  input  logic             tx_start_i,
  input  logic             err_clr_i,
  output logic             wait_err_o
);
  logic [CNT_W-1:0] lim_eff;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             viol;
  logic             restart;
  logic             stop;

  assign restart = en_i && rx_start_i;
  // T=0: a transmitted start closes the interval
  assign stop    = en_i && !proto_t1_i && tx_start_i && !rx_start_i;

  sc_wait_limit_reg #(.W(LIM_W)) u_lim (
    .clk_i, .rst_ni, .we_i(lim_we_i), .wdata_i(lim_wdata_i), .q_o(lim_rdata_o)
  );

  sc_wait_scale #(.LIM_W(LIM_W), .CNT_W(CNT_W), .MULT(T0_MULT)) u_scale (
    .raw_i(lim_rdata_o), .t1_i(proto_t1_i), .lim_o(lim_eff)
  );

  sc_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .en_i, .restart_i(restart), .stop_i(stop),
    .tick_i(etu_tick_i), .lim_i(lim_eff),
    .armed_o(armed_q), .cnt_o(cnt_q), .viol_o(viol)
  );

  sc_wait_flag u_flag (
    .clk_i, .rst_ni, .set_i(viol), .clr_i(err_clr_i), .q_o(wait_err_o)
  );
endmodule

// File: rtl/sc_wait_mon_chk.sv
module sc_wait_mon_chk #(
  parameter int unsigned LIM_W = sc_wait_pkg::LIM_W,
  parameter int unsigned CNT_W = sc_wait_pkg::CNT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             lim_we_i,
  input logic [LIM_W-1:0] lim_wdata_i,
  input logic [LIM_W-1:0] lim_rdata_o,
  input logic             err_clr_i,
  input logic             wait_err_o,
  input logic             armed_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             viol,
  input logic             restart,
  input logic             stop
);
  p_lim_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i |=> lim_rdata_o == $past(lim_wdata_i));

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_err_o && !err_clr_i) |=> wait_err_o);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !viol) |=> !wait_err_o);

  p_viol_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol |=> wait_err_o);

  p_quiet_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(wait_err_o));

  p_needs_traffic_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !$rose(wait_err_o));

  p_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart && !stop) |=> cnt_q >= $past(cnt_q));
endmodule

bind sc_wait_mon sc_wait_mon_chk #(.LIM_W(sc_wait_pkg::LIM_W), .CNT_W(sc_wait_pkg::CNT_W)) u_chk (
  .clk_i, .rst_ni, .en_i, .lim_we_i, .lim_wdata_i, .lim_rdata_o,
  .err_clr_i, .wait_err_o, .armed_q, .cnt_q, .viol, .restart, .stop
);

// File: tb/sc_wait_mon_tb_top.sv
module sc_wait_mon_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        proto_t1_i = 1'b0;
  logic        lim_we_i = 1'b0;
  logic [15:0] lim_wdata_i = '0;
  logic [15:0] lim_rdata_o;
  logic        etu_tick_i = 1'b0;
  logic        rx_start_i = 1'b0;
  logic        tx_start_i = 1'b0;
  logic        err_clr_i = 1'b0;
  logic        wait_err_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  sc_wait_mon dut_i (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask

  task automatic write_lim(logic [15:0] v);
    lim_we_i = 1'b1; lim_wdata_i = v; cyc(); lim_we_i = 1'b0;
  endtask

  task automatic rx(); rx_start_i = 1'b1; cyc(); rx_start_i = 1'b0; endtask
  task automatic tx(); tx_start_i = 1'b1; cyc(); tx_start_i = 1'b0; endtask
  task automatic clr(); err_clr_i = 1'b1; cyc(); err_clr_i = 1'b0; endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      etu_tick_i = 1'b1; cyc(); etu_tick_i = 1'b0;
    end
  endtask

  task automatic setup(logic t1, logic [15:0] v);
    proto_t1_i = t1; write_lim(v); clr();
  endtask

  task automatic t_reset();
    chk("R1 reset limit", lim_rdata_o, 16'h0);
    chk("R7 reset flag", 16'(wait_err_o), 16'h0);
  endtask

  task automatic t_lim_rw();
    write_lim(16'hA5C3);
    chk("R1 readback", lim_rdata_o, 16'hA5C3);
    write_lim(16'h0000);
    chk("R1 readback zero", lim_rdata_o, 16'h0);
  endtask

  task automatic t_t1_scale();
    setup(1'b1, 16'd5);
    rx(); ticks(5);
    chk("R2 T1 at limit", 16'(wait_err_o), 16'h0);
    ticks(1);
    chk("R2 T1 past limit", 16'(wait_err_o), 16'h1);
    ticks(3);
    chk("R7 sticky", 16'(wait_err_o), 16'h1);
    clr();
    chk("R7 cleared", 16'(wait_err_o), 16'h0);
    ticks(20);
    chk("R10 no second event", 16'(wait_err_o), 16'h0);
  endtask

  task automatic t_t1_zero();
    setup(1'b1, 16'd0);
    rx(); ticks(1);
    chk("R4 T1 zero at 1", 16'(wait_err_o), 16'h0);
    ticks(1);
    chk("R4 T1 zero past 1", 16'(wait_err_o), 16'h1);
  endtask

  task automatic t_t1_tx_ignored();
    setup(1'b1, 16'd3);
    rx(); ticks(2); tx(); ticks(1);
    chk("R5 T1 tx no restart", 16'(wait_err_o), 16'h0);
    ticks(1);
    chk("R5 T1 tx ignored", 16'(wait_err_o), 16'h1);
  endtask

  task automatic t_t1_rx_restart();
    setup(1'b1, 16'd3);
    rx(); ticks(3); rx(); ticks(3);
    chk("R5 T1 rx restart", 16'(wait_err_o), 16'h0);
    ticks(1);
    chk("R5 T1 after restart", 16'(wait_err_o), 16'h1);
  endtask

  task automatic t_t0_scale(logic [15:0] v, int lim, string tag);
    setup(1'b0, v);
    rx(); ticks(lim);
    chk({tag, " T0 at limit"}, 16'(wait_err_o), 16'h0);
    ticks(1);
    chk({tag, " T0 past limit"}, 16'(wait_err_o), 16'h1);
  endtask

  task automatic t_t0_tx_ends();
    setup(1'b0, 16'd0);
    rx(); ticks(50); tx(); ticks(100);
    chk("R6 T0 tx ends interval", 16'(wait_err_o), 16'h0);
    rx(); ticks(61);
    chk("R6 T0 rx rearms", 16'(wait_err_o), 16'h1);
  endtask

  task automatic t_enable();
    setup(1'b1, 16'd2);
    en_i = 1'b0; cyc(); en_i = 1'b1; cyc();
    ticks(50);
    chk("R9 no traffic no error", 16'(wait_err_o), 16'h0);
    en_i = 1'b0; rx(); ticks(10);
    chk("R9 disabled no error", 16'(wait_err_o), 16'h0);
    en_i = 1'b1; rx(); ticks(3);
    chk("R9 enabled error", 16'(wait_err_o), 16'h1);
    en_i = 1'b0; cyc();
    chk("R9 flag held on disable", 16'(wait_err_o), 16'h1);
    en_i = 1'b1; clr();
  endtask

  task automatic t_clr_race();
    setup(1'b1, 16'd1);
    rx(); ticks(1);
    etu_tick_i = 1'b1; err_clr_i = 1'b1; cyc();
    etu_tick_i = 1'b0; err_clr_i = 1'b0;
    chk("R8 violation beats clear", 16'(wait_err_o), 16'h1);
    clr();
    chk("R8 later clear", 16'(wait_err_o), 16'h0);
  endtask

  task automatic t_strobe_tick();
    setup(1'b1, 16'd2);
    rx(); ticks(2);
    rx_start_i = 1'b1; etu_tick_i = 1'b1; cyc();
    rx_start_i = 1'b0; etu_tick_i = 1'b0;
    chk("R11 strobe wins tick", 16'(wait_err_o), 16'h0);
    ticks(2);
    chk("R11 restart from zero", 16'(wait_err_o), 16'h0);
    ticks(1);
    chk("R11 next limit", 16'(wait_err_o), 16'h1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_ni = 1'b1; cyc();
    en_i = 1'b1;
    t_lim_rw();
    t_t1_scale();
    t_t1_zero();
    t_t1_tx_ignored();
    t_t1_rx_restart();
    t_t0_scale(16'd1, 60, "R3");
    t_t0_scale(16'd2, 120, "R3");
    t_t0_scale(16'd0, 60, "R4");
    t_t0_tx_ends();
    t_enable();
    t_clr_race();
    t_strobe_tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule